// File: doc/BRIEF.md
# Oversampled Serial Receiver with Threshold-Flagged Receive Queue

This block is the receive half of an asynchronous serial port. It takes an asynchronous line input and a 16x oversampling strobe from an external rate generator. It recovers bytes framed as one low start bit, eight data bits sent least significant first, an optional parity bit and one high stop bit. Each recovered byte goes into an eight-entry first-in first-out queue. The consumer reads the head of the queue through a read strobe.

A data-ready flag tells the consumer when enough bytes are waiting. The consumer can wire it straight to an interrupt line. A two-bit select sets the threshold for this flag. The select moves only the threshold; the queue always has room for eight bytes. A start-bit width check rejects glitches on the line, and a control input can turn the check off for test or bring-up. Parity can be even, odd or absent. Parity mismatch, a low stop bit and a byte lost to a full queue each set a sticky error flag. The flags stay set until reset.

Top module: `uart_rx_trig`

## Requirements
- R1: The line passes through a two-stage synchronizer. Each data bit is sampled at the middle of its 16 oversample ticks, and the eight data bits arrive least significant bit first, so the byte read out equals the byte sent.
- R2: With `start_chk_off` low, a low pulse shorter than half a bit time (8 ticks) is discarded. The receiver returns to idle, no byte is stored, and the next proper frame is received correctly.
- R3: With `start_chk_off` high, any falling edge on the idle line starts a frame with no width check. A 4-tick glitch on an otherwise high line, with parity off, yields a stored byte of 0xFF.
- R4: `par_sel` = 0 expects an even-parity bit (data plus parity bit hold an even number of ones). `par_sel` = 1 expects an odd-parity bit. Values 2 and 3 expect no parity bit, so the stop bit follows data bit 7 directly.
- R5: A one-cycle `fifo_clr` pulse empties the queue: `fifo_count` returns to 0 and `rda` falls.
- R6: `rda` is high exactly when `fifo_count` is at least the level chosen by `trig_sel`: 0 selects 1, 1 selects 2, 2 selects 4, 3 selects 7.
- R7: A parity mismatch sets `parity_err`, which stays high until reset, and the byte is still stored.
- R8: The queue holds 8 bytes for every `trig_sel` value, and `fifo_count` never exceeds 8.
- R9: A stop bit sampled low sets `frame_err`, which stays high until reset, and the byte is still stored.
- R10: A byte completed while the queue holds 8 entries is discarded and sets `overrun_err`, which stays high until reset. The 8 stored bytes read back unchanged and in order.
- R11: Each `rd_en` cycle with a non-empty queue removes the head and lowers the count by one. `rd_en` on an empty queue has no effect. A store and a removal in the same cycle leave the count unchanged.
- R12: After reset, `fifo_count` is 0 and `rda`, `parity_err`, `frame_err` and `overrun_err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| baud_tick | input | 1 | One-cycle strobe at 16 times the bit rate |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| start_chk_off | input | 1 | High disables the start-bit width check |
| fifo_clr | input | 1 | Synchronous queue clear |
| trig_sel | input | 2 | Data-ready threshold select |
| par_sel | input | 2 | Parity mode select |
| rd_en | input | 1 | Remove the head entry of the queue |
| rd_data | output | 8 | Head entry of the queue |
| fifo_count | output | 4 | Number of stored bytes, 0 to 8 |
| rda | output | 1 | Data-ready flag, also usable as an interrupt |
| parity_err | output | 1 | Sticky parity mismatch flag |
| frame_err | output | 1 | Sticky low-stop-bit flag |
| overrun_err | output | 1 | Sticky flag for a byte lost to a full queue |

## Verification
The bench uses the default eight-bit data width, the eight-entry queue and 16x oversampling. It holds `baud_tick` high on every cycle, so one bit lasts 16 clocks and a whole frame fits in about 180 cycles. That makes a full sweep of all 256 byte values under even parity affordable, along with broad odd and no-parity samples. Every threshold select can be driven from empty to full and then one byte past full. The sweep also covers glitch rejection and glitch acceptance in both start-check modes.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  // Queue fill needed to raise the data-ready flag.
  function automatic int trig_level(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 2;
      2'd2:    return 4;
      default: return 7;
    endcase
  endfunction

  // Parity bit a sender adds: even mode gives XOR of data, odd inverts it.
  function automatic logic parity_bit(input logic [7:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  // Modes 0 and 1 carry a parity bit, 2 and 3 do not.
  function automatic logic parity_on(input logic [1:0] sel);
    return !sel[1];
  endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic d_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import uart_rx_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rx_s,
  input  logic          chk_off,
  input  logic [1:0]    par_sel,
  output logic          done,
  output logic [DW-1:0] data,
  output logic          par_bad,
  output logic          stop_bad
);
  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(DW);
  localparam logic [CW-1:0] CNT_LAST = CW'(OVS - 1);
  localparam logic [CW-1:0] CNT_HALF = CW'(OVS / 2 - 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(DW - 1);

  rx_state_e      state;
  logic [CW-1:0]  cnt;
  logic [BW-1:0]  bitn;
  logic [DW-1:0]  shreg;
  logic           rx_prev;
  logic           par_smp;
  logic           fall;
  logic           mid_bit;

  assign fall    = rx_prev && !rx_s;
  assign mid_bit = tick && (cnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      bitn     <= '0;
      shreg    <= '0;
      rx_prev  <= 1'b1;
      par_smp  <= 1'b0;
      done     <= 1'b0;
      data     <= '0;
      par_bad  <= 1'b0;
      stop_bad <= 1'b0;
    end else begin
      rx_prev <= rx_s;
      done    <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (fall) begin
            state <= ST_START;
            cnt   <= '0;
          end
        end
        ST_START: begin
          if (tick) begin
            if (!chk_off && rx_s) begin
              state <= ST_IDLE;
            end else if (cnt == CNT_HALF) begin
              state <= ST_DATA;
              cnt   <= '0;
              bitn  <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (mid_bit) begin
            shreg <= {rx_s, shreg[DW-1:1]};
            cnt   <= '0;
            if (bitn == BIT_LAST) state <= parity_on(par_sel) ? ST_PAR : ST_STOP;
            else                  bitn  <= bitn + 1'b1;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_PAR: begin
          if (mid_bit) begin
            par_smp <= rx_s;
            cnt     <= '0;
            state   <= ST_STOP;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (mid_bit) begin
            done     <= 1'b1;
            data     <= shreg;
            par_bad  <= parity_on(par_sel) &&
                        (par_smp != parity_bit(shreg, par_sel[0]));
            stop_bad <= !rx_s;
            cnt      <= '0;
            state    <= ST_IDLE;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       push,
  input  logic [DW-1:0]              wdata,
  input  logic                       pop,
  output logic [DW-1:0]              rdata,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       push_ok,
  output logic                       pop_ok
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr;

  assign full    = (count == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && (count != '0);
  assign rdata   = mem[rptr];

  always_ff @(posedge clk) begin
    if (push_ok && !clr) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= (wptr == PTR_LAST) ? '0 : wptr + 1'b1;
      if (pop_ok)  rptr <= (rptr == PTR_LAST) ? '0 : rptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_trig.sv
module uart_rx_trig
  import uart_rx_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  parameter int OVS   = 16,
  parameter int SYNC  = 2,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            baud_tick,
  input  logic            rx_in,
  input  logic            start_chk_off,
  input  logic            fifo_clr,
  input  logic [1:0]      trig_sel,
  input  logic [1:0]      par_sel,
  input  logic            rd_en,
  output logic [DW-1:0]   rd_data,
  output logic [CNTW-1:0] fifo_count,
  output logic            rda,
  output logic            parity_err,
  output logic            frame_err,
  output logic            overrun_err
);
  logic          rx_s;
  logic          byte_done;
  logic [DW-1:0] byte_data;
  logic          byte_par_bad;
  logic          byte_stop_bad;
  logic          fifo_full;
  logic          push_evt;
  logic          pop_evt;
  logic          drop_evt;

  rx_sync #(.STAGES(SYNC)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (rx_in),
    .d_sync  (rx_s)
  );

  rx_frame #(.DW(DW), .OVS(OVS)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (baud_tick),
    .rx_s     (rx_s),
    .chk_off  (start_chk_off),
    .par_sel  (par_sel),
    .done     (byte_done),
    .data     (byte_data),
    .par_bad  (byte_par_bad),
    .stop_bad (byte_stop_bad)
  );

  rx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (fifo_clr),
    .push    (byte_done),
    .wdata   (byte_data),
    .pop     (rd_en),
    .rdata   (rd_data),
    .count   (fifo_count),
    .full    (fifo_full),
    .push_ok (push_evt),
    .pop_ok  (pop_evt)
  );

  assign drop_evt = byte_done && fifo_full;
  assign rda      = (int'(fifo_count) >= trig_level(trig_sel));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      parity_err  <= 1'b0;
      frame_err   <= 1'b0;
      overrun_err <= 1'b0;
    end else begin
      if (byte_done && byte_par_bad)  parity_err  <= 1'b1;
      if (byte_done && byte_stop_bad) frame_err   <= 1'b1;
      if (drop_evt)                   overrun_err <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_rx_trig_chk.sv
module uart_rx_trig_chk #(
  parameter int DEPTH = 8,
  parameter int CNTW  = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            fifo_clr,
  input logic [CNTW-1:0] fifo_count,
  input logic            rda,
  input logic            parity_err,
  input logic            frame_err,
  input logic            overrun_err,
  input logic            byte_done,
  input logic            fifo_full,
  input logic            push_evt,
  input logic            pop_evt
);
  p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CNTW'(DEPTH));

  p_clear_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> (fifo_count == '0 && !rda));

  p_rda_needs_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rda |-> (fifo_count != '0));

  p_full_raises_rda_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_count == CNTW'(DEPTH)) |-> rda);

  p_drop_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && fifo_full) |=> overrun_err);

  p_overrun_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_err |=> overrun_err);

  p_parity_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    parity_err |=> parity_err);

  p_frame_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> frame_err);

  p_push_pop_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (push_evt && pop_evt && !fifo_clr) |=> $stable(fifo_count));

  p_pop_lowers_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_evt && !push_evt && !fifo_clr) |=> (fifo_count == $past(fifo_count) - 1'b1));

  p_push_raises_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (push_evt && !pop_evt && !fifo_clr) |=> (fifo_count == $past(fifo_count) + 1'b1));
endmodule

bind uart_rx_trig uart_rx_trig_chk #(.DEPTH(DEPTH), .CNTW(CNTW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fifo_clr    (fifo_clr),
  .fifo_count  (fifo_count),
  .rda         (rda),
  .parity_err  (parity_err),
  .frame_err   (frame_err),
  .overrun_err (overrun_err),
  .byte_done   (byte_done),
  .fifo_full   (fifo_full),
  .push_evt    (push_evt),
  .pop_evt     (pop_evt)
);

// File: tb/uart_rx_trig_tb.sv
module uart_rx_trig_tb;
  localparam int BITCLK = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b1;
  logic       rx_in = 1'b1;
  logic       start_chk_off = 1'b0;
  logic       fifo_clr = 1'b0;
  logic [1:0] trig_sel = 2'd0;
  logic [1:0] par_sel = 2'd0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic [3:0] fifo_count;
  logic       rda;
  logic       parity_err;
  logic       frame_err;
  logic       overrun_err;

  int n_vec  = 0;
  int n_fail = 0;
  bit done_run = 1'b0;

  always #2.5 clk = ~clk;

  uart_rx_trig u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .baud_tick     (baud_tick),
    .rx_in         (rx_in),
    .start_chk_off (start_chk_off),
    .fifo_clr      (fifo_clr),
    .trig_sel      (trig_sel),
    .par_sel       (par_sel),
    .rd_en         (rd_en),
    .rd_data       (rd_data),
    .fifo_count    (fifo_count),
    .rda           (rda),
    .parity_err    (parity_err),
    .frame_err     (frame_err),
    .overrun_err   (overrun_err)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_run) begin
      done_run = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  endtask

  function automatic int level_of(input int sel);
    return (sel == 3) ? 7 : (1 << sel);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic drive_bit(input logic v);
    rx_in = v;
    repeat (BITCLK) @(negedge clk);
  endtask

  // Start, 8 data bits LSB first, optional parity, stop, short idle.
  task automatic send_frame(input logic [7:0] d, input logic [1:0] ps,
                            input bit flip_par, input bit bad_stop);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i]);
    if (ps < 2) drive_bit(((^d) ^ ps[0]) ^ flip_par);
    drive_bit(!bad_stop);
    rx_in = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic pop_check(input string tag, input int exp);
    check(tag, rd_data, exp);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic glitch();
    rx_in = 1'b0;
    repeat (4) @(negedge clk);
    rx_in = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_vec++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    // R12: reset state
    check("R12 count", fifo_count, 0);
    check("R12 rda", rda, 0);
    check("R12 parity_err", parity_err, 0);
    check("R12 frame_err", frame_err, 0);
    check("R12 overrun_err", overrun_err, 0);

    // R1 / R4: every byte under even parity
    par_sel = 2'd0;
    for (int b = 0; b < 256; b++) begin
      send_frame(8'(b), 2'd0, 1'b0, 1'b0);
      check("R1 count after frame", fifo_count, 1);
      pop_check("R1 even data", b);
    end
    // R4: odd parity and no parity samples
    for (int k = 0; k < 64; k++) begin
      par_sel = 2'd1;
      send_frame(8'(k * 4 + 1), 2'd1, 1'b0, 1'b0);
      pop_check("R4 odd data", k * 4 + 1);
    end
    for (int k = 0; k < 64; k++) begin
      par_sel = (k < 32) ? 2'd2 : 2'd3;
      send_frame(8'(k * 4 + 2), par_sel, 1'b0, 1'b0);
      pop_check("R4 no-parity data", k * 4 + 2);
    end
    check("R4 parity_err after clean sweep", parity_err, 0);
    check("R9 frame_err after clean sweep", frame_err, 0);
    check("R11 count after sweep", fifo_count, 0);

    // R2: short glitch rejected with check on
    par_sel = 2'd0;
    start_chk_off = 1'b0;
    glitch();
    repeat (250) @(negedge clk);
    check("R2 glitch stored nothing", fifo_count, 0);
    send_frame(8'hA5, 2'd0, 1'b0, 1'b0);
    pop_check("R2 frame after glitch", 8'hA5);

    // R3: same glitch accepted with check off, parity off
    start_chk_off = 1'b1;
    par_sel = 2'd2;
    glitch();
    repeat (250) @(negedge clk);
    check("R3 glitch frame stored", fifo_count, 1);
    pop_check("R3 glitch data", 8'hFF);
    start_chk_off = 1'b0;
    par_sel = 2'd0;

    // R11: read on empty has no effect
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
    check("R11 pop on empty", fifo_count, 0);
    send_frame(8'h3C, 2'd0, 1'b0, 1'b0);
    pop_check("R11 data after empty pop", 8'h3C);

    // R6 / R8 / R10: thresholds, full depth, overrun
    for (int s = 0; s < 4; s++) begin
      trig_sel = 2'(s);
      for (int k = 0; k < 8; k++) begin
        send_frame(8'(s * 16 + k), 2'd0, 1'b0, 1'b0);
        check("R8 count while filling", fifo_count, k + 1);
        check("R6 rda vs level", rda, (k + 1 >= level_of(s)) ? 1 : 0);
      end
      if (s == 0) check("R10 no overrun before ninth", overrun_err, 0);
      send_frame(8'hEE, 2'd0, 1'b0, 1'b0);
      check("R10 overrun set", overrun_err, 1);
      check("R8 count capped", fifo_count, 8);
      for (int k = 0; k < 8; k++) begin
        pop_check("R10 stored bytes intact", s * 16 + k);
        check("R11 count after pop", fifo_count, 7 - k);
      end
      check("R6 rda when empty", rda, 0);
    end

    // R5: queue clear
    trig_sel = 2'd1;
    for (int k = 0; k < 3; k++) send_frame(8'(k + 100), 2'd0, 1'b0, 1'b0);
    check("R5 count before clear", fifo_count, 3);
    check("R5 rda before clear", rda, 1);
    fifo_clr = 1'b1;
    @(negedge clk);
    fifo_clr = 1'b0;
    @(negedge clk);
    check("R5 count after clear", fifo_count, 0);
    check("R5 rda after clear", rda, 0);
    trig_sel = 2'd0;

    // R7: parity mismatch still stores byte
    do_reset();
    send_frame(8'h5A, 2'd0, 1'b1, 1'b0);
    check("R7 parity_err set", parity_err, 1);
    check("R7 byte stored", fifo_count, 1);
    pop_check("R7 data", 8'h5A);
    par_sel = 2'd1;
    send_frame(8'h11, 2'd1, 1'b1, 1'b0);
    pop_check("R7 odd mismatch data", 8'h11);
    check("R7 parity_err stays", parity_err, 1);
    check("R9 frame_err untouched", frame_err, 0);
    par_sel = 2'd0;

    // R9: low stop bit
    do_reset();
    send_frame(8'hC3, 2'd0, 1'b0, 1'b1);
    repeat (20) @(negedge clk);
    check("R9 frame_err set", frame_err, 1);
    check("R9 byte stored", fifo_count, 1);
    pop_check("R9 data", 8'hC3);
    check("R7 parity_err untouched", parity_err, 0);

    finish_run();
  end
endmodule